// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This unit multiplies two operand words and keeps the double-width result in a pair of registers, HI and LO. The pair works as a single accumulator: HI holds the upper half and LO the lower half. Six operations are available. Each of overwrite, add-to-accumulator and subtract-from-accumulator comes in a signed form and an unsigned form. The signedness only changes how the operands are extended before they are multiplied. Both accumulate forms wrap modulo 2^(2*DATA_W).

The multiplier is iterative and consumes STEP_BITS bits of the second operand per cycle. The unit takes a start strobe together with an operation code and two operands. It stays busy until the result is written, and it ignores further strobes during that time. Software can also load HI and LO directly through two separate write ports, for example to restore a saved accumulator. In the cycle a result is written, the HI and LO outputs already show the new value.

Top module: `hilo_mac`

## Requirements
- R1: After reset, hi and lo read zero and both done and busy are low.
- R2: Code 3'b000 loads HI:LO with the signed product (both operands sign-extended). Code 3'b001 loads it with the unsigned product (both operands zero-extended). HI holds bits 2W-1:W of the result and LO holds bits W-1:0.
- R3: Codes 3'b010 (signed) and 3'b011 (unsigned) add the product to HI:LO, modulo 2^(2W).
- R4: Codes 3'b100 (signed) and 3'b101 (unsigned) subtract the product from HI:LO, modulo 2^(2W).
- R5: Let E be the clock edge at which a start is accepted. Then busy is high from E until the result is written. done is high for exactly one cycle: the DATA_W/STEP_BITS-th cycle after E, which is the cycle before the write edge. busy is also high during that cycle, and both signals are low afterwards.
- R6: A start strobe while busy is high is ignored. The running operation completes with its own operands, and no extra done follows.
- R7: A start with code 3'b110 or 3'b111 is ignored. busy and done stay low, and HI and LO are unchanged.
- R8: hi_we loads hi_wdata into HI, and lo_we loads lo_wdata into LO. Each new value is visible from the next cycle, and each port leaves the other register unchanged.
- R9: In the cycle in which done is high, hi and lo already present the new result.
- R10: An accumulate uses HI:LO as it stands in the done cycle, so it includes direct writes made while busy. A direct write in the done cycle is discarded in favour of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe |
| op | input | 3 | Operation code |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand |
| hi_we | input | 1 | HI direct write enable |
| hi_wdata | input | DATA_W | HI direct write data |
| lo_we | input | 1 | LO direct write enable |
| lo_wdata | input | DATA_W | LO direct write data |
| hi | output | DATA_W | HI value (result forwarded in done cycle) |
| lo | output | DATA_W | LO value (result forwarded in done cycle) |
| done | output | 1 | One-cycle result-written flag |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the unit with DATA_W=32 and STEP_BITS=4, which gives eight iterations per operation. Running full-width operands makes the sign-extension corner cases reachable: the most negative value squared, all-ones unsigned operands, and subtraction through zero. The eight-cycle window also leaves room to inject a second strobe and a direct LO write in the middle of an operation, and a HI write exactly in the done cycle.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

    typedef enum logic [1:0] {
        ACC_SET = 2'd0,
        ACC_ADD = 2'd1,
        ACC_SUB = 2'd2
    } acc_mode_e;

    // op[0] selects unsigned, op[2:1] selects the accumulate mode
    function automatic logic op_valid(input logic [2:0] op);
        return op[2:1] != 2'b11;
    endfunction

    function automatic logic op_signed(input logic [2:0] op);
        return !op[0];
    endfunction

    function automatic acc_mode_e op_mode(input logic [2:0] op);
        case (op[2:1])
            2'b01:   return ACC_ADD;
            2'b10:   return ACC_SUB;
            default: return ACC_SET;
        endcase
    endfunction

endpackage

// File: rtl/hilo_mul_iter.sv
module hilo_mul_iter #(
    parameter int DATA_W    = 32,
    parameter int STEP_BITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  sgn,
    input  logic [DATA_W-1:0]     a,
    input  logic [DATA_W-1:0]     b,
    output logic                  busy_o,
    output logic                  last_o,
    output logic [2*DATA_W-1:0]   prod_o
);
    localparam int STEPS = DATA_W / STEP_BITS;
    localparam int CW    = $clog2(STEPS + 1);
    localparam int PW    = 2 * DATA_W;

    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [PW-1:0]     mcand;
        logic [DATA_W-1:0] mplier;
        logic [PW-1:0]     prod;
        logic              negb;
    } iter_t;

    iter_t st_q, st_d;
    logic [PW-1:0] partial, sum, corr;
    logic          last;

    always_comb begin
        partial = '0;
        for (int i = 0; i < STEP_BITS; i++) begin
            if (st_q.mplier[i]) partial = partial + (st_q.mcand << i);
        end
        sum  = st_q.prod + partial;
        // two's complement fix-up for a negative second operand
        corr = st_q.negb ? (st_q.mcand << STEP_BITS) : '0;
        last = st_q.busy && (st_q.cnt == CW'(1));

        st_d = st_q;
        if (load) begin
            st_d.busy   = 1'b1;
            st_d.cnt    = CW'(STEPS);
            st_d.mcand  = sgn ? {{DATA_W{a[DATA_W-1]}}, a} : {{DATA_W{1'b0}}, a};
            st_d.mplier = b;
            st_d.prod   = '0;
            st_d.negb   = sgn & b[DATA_W-1];
        end else if (st_q.busy) begin
            st_d.prod   = sum;
            st_d.mcand  = st_q.mcand << STEP_BITS;
            st_d.mplier = st_q.mplier >> STEP_BITS;
            st_d.cnt    = st_q.cnt - CW'(1);
            if (last) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign last_o = last;
    assign prod_o = sum - corr;
endmodule

// File: rtl/hilo_acc.sv
module hilo_acc #(
    parameter int DATA_W = 32
) (
    input  hilo_mac_pkg::acc_mode_e mode,
    input  logic [2*DATA_W-1:0]     acc,
    input  logic [2*DATA_W-1:0]     prod,
    output logic [2*DATA_W-1:0]     res
);
    import hilo_mac_pkg::*;

    always_comb begin
        case (mode)
            ACC_ADD: res = acc + prod;
            ACC_SUB: res = acc - prod;
            default: res = prod;
        endcase
    end
endmodule

// File: rtl/hilo_mac.sv
module hilo_mac #(
    parameter int DATA_W    = 32,
    parameter int STEP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] hi_wdata,
    input  logic              lo_we,
    input  logic [DATA_W-1:0] lo_wdata,
    output logic [DATA_W-1:0] hi,
    output logic [DATA_W-1:0] lo,
    output logic              done,
    output logic              busy
);
    import hilo_mac_pkg::*;

    localparam int PW = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        acc_mode_e         mode;
    } mac_t;

    mac_t          st_q, st_d;
    logic          go, it_busy, it_last;
    logic [PW-1:0] prod, res;

    hilo_mul_iter #(.DATA_W(DATA_W), .STEP_BITS(STEP_BITS)) u_iter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (go),
        .sgn    (op_signed(op)),
        .a      (opa),
        .b      (opb),
        .busy_o (it_busy),
        .last_o (it_last),
        .prod_o (prod)
    );

    hilo_acc #(.DATA_W(DATA_W)) u_acc (
        .mode (st_q.mode),
        .acc  ({st_q.hi, st_q.lo}),
        .prod (prod),
        .res  (res)
    );

    always_comb begin
        go   = start && !it_busy && op_valid(op);
        st_d = st_q;
        if (go) st_d.mode = op_mode(op);
        if (it_last) begin
            st_d.hi = res[PW-1:DATA_W];
            st_d.lo = res[DATA_W-1:0];
        end else begin
            if (hi_we) st_d.hi = hi_wdata;
            if (lo_we) st_d.lo = lo_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hi: '0, lo: '0, mode: ACC_SET};
        else        st_q <= st_d;
    end

    assign hi   = it_last ? res[PW-1:DATA_W]  : st_q.hi;
    assign lo   = it_last ? res[DATA_W-1:0]   : st_q.lo;
    assign done = it_last;
    assign busy = it_busy;
endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        op,
    input logic              hi_we,
    input logic [DATA_W-1:0] hi_wdata,
    input logic              lo_we,
    input logic [DATA_W-1:0] lo_wdata,
    input logic [DATA_W-1:0] hi,
    input logic [DATA_W-1:0] lo,
    input logic              done,
    input logic              busy
);
    import hilo_mac_pkg::*;

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_idle_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_bad_code_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op_valid(op)) |=> !busy);

    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (hi == $past(hi) && lo == $past(lo)));

    assert_hi_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !done) |=> (done || hi == $past(hi_wdata)));

    assert_lo_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !done) |=> (done || lo == $past(lo_wdata)));
endmodule

bind hilo_mac hilo_mac_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .hi_we    (hi_we),
    .hi_wdata (hi_wdata),
    .lo_we    (lo_we),
    .lo_wdata (lo_wdata),
    .hi       (hi),
    .lo       (lo),
    .done     (done),
    .busy     (busy)
);

// File: tb/hilo_mac_tb_top.sv
module hilo_mac_tb_top;
    localparam int W     = 32;
    localparam int SB    = 4;
    localparam int STEPS = W / SB;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] opa = '0, opb = '0;
    logic         hi_we = 1'b0, lo_we = 1'b0;
    logic [W-1:0] hi_wdata = '0, lo_wdata = '0;
    logic [W-1:0] hi, lo;
    logic         done, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [63:0] model = '0;
    logic [63:0] sb_q[$];

    always #5 clk = ~clk;

    hilo_mac #(.DATA_W(W), .STEP_BITS(SB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
        .hi(hi), .lo(lo), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] product(input logic [2:0] c, input logic [31:0] a,
                                            input logic [31:0] b);
        logic [63:0] ea, eb;
        ea = c[0] ? {32'h0, a} : {{32{a[31]}}, a};
        eb = c[0] ? {32'h0, b} : {{32{b[31]}}, b};
        return ea * eb;
    endfunction

    // monitor: compares each result in its done cycle (R9)
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6 unexpected done", {hi, lo}, 64'h0);
            end else begin
                logic [63:0] e;
                e = sb_q.pop_front();
                check({hi, lo} == e, "R9 result in done cycle", {hi, lo}, e);
            end
        end
    end

    task automatic run_op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                          input bit late_start, input bit wr_mid, input bit wr_done,
                          input string req);
        logic [63:0] base, e;
        int cyc;
        base = model;
        if (wr_mid) base[31:0] = 32'h1357_9BDF;
        case (c[2:1])
            2'b01:   e = base + product(c, a, b);
            2'b10:   e = base - product(c, a, b);
            default: e = product(c, a, b);
        endcase
        model = e;
        sb_q.push_back(e);
        @(negedge clk);
        start = 1'b1; op = c; opa = a; opb = b;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
            if (wr_mid && cyc == 2) begin lo_we = 1'b1; lo_wdata = 32'h1357_9BDF; end
            if (late_start && cyc == 3) begin start = 1'b1; op = 3'd0; opa = 7; opb = 7; end
            if (!done) check(busy == 1'b1, "R5 busy while running", {63'h0, busy}, 64'h1);
        end while (!done && cyc < 100);
        check(cyc == STEPS, "R5 done latency", 64'(cyc), 64'(STEPS));
        if (wr_done) begin hi_we = 1'b1; hi_wdata = 32'hDEAD_BEEF; end
        @(negedge clk);
        hi_we = 1'b0;
        check(done == 1'b0 && busy == 1'b0, "R5 done one cycle", {62'h0, done, busy}, 64'h0);
        check({hi, lo} == e, req, {hi, lo}, e);
    endtask

    task automatic direct_write(input bit whi, input logic [31:0] v);
        @(negedge clk);
        if (whi) begin hi_we = 1'b1; hi_wdata = v; model[63:32] = v; end
        else     begin lo_we = 1'b1; lo_wdata = v; model[31:0]  = v; end
        @(negedge clk);
        hi_we = 1'b0; lo_we = 1'b0;
        check({hi, lo} == model, "R8 direct write", {hi, lo}, model);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({hi, lo} == 64'h0, "R1 reset hilo", {hi, lo}, 64'h0);
        check(done == 1'b0 && busy == 1'b0, "R1 reset flags", {62'h0, done, busy}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(3'b000, 32'hFFFF_FFFD, 32'd5, 0, 0, 0, "R2 signed mul -3*5");
        run_op(3'b000, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, "R2 signed min squared");
        run_op(3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R2 unsigned all ones");
        run_op(3'b001, 32'h1234_5678, 32'h0, 0, 0, 0, "R2 unsigned by zero");
        run_op(3'b010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R3 signed madd");
        direct_write(1, 32'hFFFF_FFFF);
        direct_write(0, 32'hFFFF_FFF0);
        run_op(3'b011, 32'h0000_0100, 32'h0000_0100, 0, 0, 0, "R3 unsigned madd wrap");
        run_op(3'b100, 32'h0001_0000, 32'h0001_0000, 0, 0, 0, "R4 signed msub below zero");
        run_op(3'b101, 32'hFFFF_FFFF, 32'h0000_0002, 0, 0, 0, "R4 unsigned msub");
        run_op(3'b100, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 0, "R4 signed msub neg operands");
        run_op(3'b001, 32'd1000, 32'd3000, 1, 0, 0, "R6 strobe while busy ignored");

        // R7: undefined codes
        for (int k = 6; k < 8; k++) begin
            @(negedge clk);
            start = 1'b1; op = 3'(k); opa = 32'd9; opb = 32'd9;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b0 && done == 1'b0, "R7 bad code no busy", {62'h0, busy, done}, 64'h0);
            repeat (STEPS + 1) @(negedge clk);
            check({hi, lo} == model, "R7 bad code hilo kept", {hi, lo}, model);
        end

        direct_write(1, 32'h0000_0002);
        direct_write(0, 32'h8000_0000);
        run_op(3'b011, 32'd3, 32'd4, 0, 1, 0, "R10 accumulate sees mid write");
        run_op(3'b000, 32'd6, 32'hFFFF_FFF9, 0, 0, 1, "R10 done-cycle write dropped");

        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R6 all results seen", 64'(sb_q.size()), 64'h0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule